// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests from a parameterized number of maskable peripheral sources, one non-maskable source and one address-break source. It forwards one request at a time to the CPU as a registered request line and a vector number. Each maskable source has a sticky status flag and an enable bit. Both sit behind a small register port, so software can read them, write the enables and clear flags.

Selection uses a fixed priority. The CPU's global mask bit holds back the maskable sources. It does not affect the non-maskable or address-break inputs. A request that is not selected stays recorded until software clears it, so it is presented later.

An acknowledge pulse from the CPU drops the request line for one cycle. When the acknowledged vector is the non-maskable one, the pulse also retires the non-maskable latch.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A high level on `src_req[i]` at a clock edge sets status flag i. The flags read back on `reg_rdata` while `reg_addr` is 0, with bit i belonging to source i.
- R2: A write with `reg_addr` 0 clears flag i only where `reg_wdata[i]` is 0. A 1 bit leaves the flag alone. If `src_req[i]` is high in the same cycle, the flag stays set.
- R3: The enable bits are written and read with `reg_addr` 1. Source i is forwarded only while both its flag and its enable bit are 1.
- R4: The priority order is fixed, highest first:
  - the non-maskable source, vector 0;
  - address break, vector 1;
  - maskable source i, vector i+2, where a lower index wins.
- R5: While `i_mask` is 1, no maskable source is presented. It stays pending. The non-maskable and address-break requests are presented regardless of `i_mask`.
- R6: When the selected maskable flag is cleared, the next enabled pending source is presented. Unselected requests are never lost.
- R7: A rising edge on `nmi_in` sets a latch that requests vector 0. The latch is cleared only by an acknowledge while vector 0 is presented. A level that stays high gives no new request.
- R8: `irq_req` and `irq_vec` are registered. They reflect the inputs and state at the previous edge. An `irq_ack` pulse forces `irq_req` low in the following cycle, and selection resumes after that.
- R9: Reset clears the flags, the enables, the non-maskable latch and `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_SRC | Maskable source request levels |
| nmi_in | input | 1 | Non-maskable request, edge detected |
| brk_req | input | 1 | Address-break request level |
| i_mask | input | 1 | CPU global interrupt mask, 1 = masked |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status flags, 1 = enable bits |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data for the addressed register |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_req | output | 1 | Registered request to the CPU |
| irq_vec | output | VEC_W | Registered vector number |

## Verification
The bench builds the block with N_SRC = 6. With that value, the eight vectors exactly fill a 3-bit vector field, so the lowest-priority source reaches the top code 7. With all six flags pending, the enable patterns in the table reach the high end, the low end and middle positions of the priority encoder. Directed steps then cover the clear-versus-set collision, acknowledge hold-off, and a non-maskable level held across its acknowledge.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  localparam int VEC_W = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             nmi_in,
  input  logic             brk_req,
  input  logic             i_mask,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  logic [N_SRC-1:0] flag_q, en_q, cand;
  logic             nmi_d, nmi_pend;
  logic             any_req;
  logic [VEC_W-1:0] sel_vec;

  wire wr_flags = reg_wr & ~reg_addr;
  wire wr_en    = reg_wr &  reg_addr;
  wire nmi_rise = nmi_in & ~nmi_d;
  wire nmi_ack  = irq_ack & irq_req & (irq_vec == '0);

  assign cand      = flag_q & en_q & {N_SRC{~i_mask}};
  assign any_req   = nmi_pend | brk_req | (|cand);
  assign reg_rdata = reg_addr ? en_q : flag_q;

  always_comb begin
    sel_vec = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (cand[i]) sel_vec = VEC_W'(i + 2);
    if (brk_req)  sel_vec = VEC_W'(1);
    if (nmi_pend) sel_vec = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= '0;
      en_q     <= '0;
      nmi_d    <= 1'b0;
      nmi_pend <= 1'b0;
      irq_req  <= 1'b0;
      irq_vec  <= '0;
    end else begin
      flag_q   <= (wr_flags ? (flag_q & reg_wdata) : flag_q) | src_req;
      if (wr_en) en_q <= reg_wdata;
      nmi_d    <= nmi_in;
      nmi_pend <= nmi_rise | (nmi_pend & ~nmi_ack);
      irq_req  <= irq_ack ? 1'b0 : any_req;
      irq_vec  <= sel_vec;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_in,
  input logic             brk_req,
  input logic             i_mask,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             irq_ack,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [N_SRC-1:0] flag_q
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  a_r8_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_req);

  a_r7_nmi_edge_requests: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nmi_in) ##1 !irq_ack) |=> (irq_req && irq_vec == '0));

  a_r5_mask_holds_sources: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(i_mask) && irq_req) |-> (irq_vec <= VEC_W'(1)));

  a_r4_break_over_sources: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(brk_req) && !$past(irq_ack)) |-> (irq_req && irq_vec <= VEC_W'(1)));

  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .brk_req(brk_req),
  .i_mask(i_mask), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec), .flag_q(flag_q)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int N = 6;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_req = '0, reg_wdata = '0;
  logic nmi_in = 1'b0, brk_req = 1'b0, i_mask = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0, irq_ack = 1'b0;
  logic [N-1:0] reg_rdata;
  logic irq_req;
  logic [VW-1:0] irq_vec;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .nmi_in(nmi_in),
    .brk_req(brk_req), .i_mask(i_mask), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // row: enables, i_mask, brk_req, expected req, expected vec
  localparam int ROWS = 8;
  localparam logic [N+3+VW-1:0] TBL [ROWS] = '{
    {6'b000000, 1'b0, 1'b0, 1'b0, 3'd0},
    {6'b100000, 1'b0, 1'b0, 1'b1, 3'd7},
    {6'b101000, 1'b0, 1'b0, 1'b1, 3'd5},
    {6'b101001, 1'b0, 1'b0, 1'b1, 3'd2},
    {6'b101001, 1'b1, 1'b0, 1'b0, 3'd0},
    {6'b101001, 1'b1, 1'b1, 1'b1, 3'd1},
    {6'b000000, 1'b0, 1'b1, 1'b1, 3'd1},
    {6'b010000, 1'b0, 1'b0, 1'b1, 3'd6}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk_out(input string tag, input logic er, input logic [VW-1:0] ev);
    checks++;
    if (irq_req !== er || (er && irq_vec !== ev)) begin
      errors++;
      $display("FAIL %s req=%0b vec=%0d expected req=%0b vec=%0d", tag, irq_req, irq_vec, er, ev);
    end
  endtask

  task automatic chk_reg(input string tag, input logic a, input logic [N-1:0] ev);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== ev) begin
      errors++;
      $display("FAIL %s rdata=%b expected %b", tag, reg_rdata, ev);
    end
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    chk_out("R9 reset req", 1'b0, '0);
    chk_reg("R9 reset flags", 1'b0, '0);
    chk_reg("R9 reset enables", 1'b1, '0);

    src_req = '1; tick(); src_req = '0;
    chk_reg("R1 flags set", 1'b0, 6'b111111);

    for (int r = 0; r < ROWS; r++) begin
      wr(1'b1, TBL[r][N+3+VW-1:3+VW]);
      i_mask = TBL[r][2+VW];
      brk_req = TBL[r][1+VW];
      tick();
      chk_out($sformatf("R3 R4 R5 row %0d", r), TBL[r][VW], TBL[r][VW-1:0]);
    end
    brk_req = 1'b0; i_mask = 1'b0;
    chk_reg("R3 enable readback", 1'b1, 6'b010000);

    wr(1'b0, 6'b111110);
    chk_reg("R2 clear bit0 only", 1'b0, 6'b111110);
    src_req = 6'b000010;
    wr(1'b0, 6'b000000);
    src_req = '0;
    chk_reg("R2 set wins over clear", 1'b0, 6'b000010);

    src_req = 6'b010100; tick(); src_req = '0;
    wr(1'b1, 6'b111111);
    tick();
    chk_out("R4 lowest index", 1'b1, 3'd3);
    wr(1'b0, 6'b111101);
    tick();
    chk_out("R6 next pending", 1'b1, 3'd4);

    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk_out("R8 ack holdoff", 1'b0, '0);
    tick();
    chk_out("R8 resumes", 1'b1, 3'd4);

    i_mask = 1'b1; tick(); tick();
    chk_out("R5 masked pending", 1'b0, '0);
    nmi_in = 1'b1; tick(); tick();
    chk_out("R7 R5 nmi despite mask", 1'b1, 3'd0);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk_out("R8 nmi ack holdoff", 1'b0, '0);
    tick();
    chk_out("R7 level held no rearm", 1'b0, '0);

    nmi_in = 1'b0; tick();
    nmi_in = 1'b1; brk_req = 1'b1; tick(); tick();
    chk_out("R4 nmi over break", 1'b1, 3'd0);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
    chk_out("R4 R5 break after nmi", 1'b1, 3'd1);
    brk_req = 1'b0; i_mask = 1'b0; tick(); tick();
    chk_out("R6 source still pending", 1'b1, 3'd4);
    chk_reg("R6 flags kept", 1'b0, 6'b010100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule